// File: doc/BRIEF.md
# Partition-Based Reference Fetch Collector

This block sits between motion-vector reconstruction and the interpolation stage of a video decoder's motion-compensation path. For each motion partition (4, 8 or 16 pixels on a side) it issues a single request for reference pixels. The request window is sized from the partition dimensions and grows by five pixels only along the axes where the motion vector has a fractional part. The origin is the integer-pel target, pulled back two pixels on each fractional axis so that the six-tap filter has its left and upper context.

Rows come back from the memory side one per beat, up to 21 pixels wide. They are stacked from the top-left corner of a 21x21 pixel register array. Each 4x4 sub-block of the partition reads its own window from a fixed place in that array. A window is written to a 16-entry reference data buffer as soon as the rows it needs are present, so writes start while later rows are still arriving. Windows are written in raster order within the partition. A busy flag holds off the next partition until the last window of the current one has been written. The array is then refilled by the next partition.

Top module: `ref_fetch_collector`

## Requirements
- R1: During and right after reset, `busy`, `req_valid` and `wr_en` are all 0.
- R2: When `start` is sampled high with `busy` low, `req_valid` is high for exactly the next cycle. At that point `req_w` is M+5 if the low FRAC_BITS (2) bits of `mv_x` are nonzero, else M. `req_h` is N+5 if the low two bits of `mv_y` are nonzero, else N.
- R3: `req_x` equals `pos_x + floor(mv_x/4)`, minus 2 when `mv_x` is fractional. `req_y` follows the same rule using `pos_y` and `mv_y`. Both are signed results.
- R4: A `start` sampled while `busy` is high produces no request and does not change the partition in progress.
- R5: Each beat with `row_valid` high while `busy` is high stores `row_data` as the next array row, in arrival order, up to `req_h` rows. Pixel k of a beat occupies bits [8k+7:8k].
- R6: A partition of M x N gives (M/4)(N/4) buffer writes in raster order (sub-block column i fastest, then row j). Each write goes to entry `wr_idx = (sub_y+j)*4 + (sub_x+i)`.
- R7: Window pixel (r,c), at bits [(9r+c)*8+7:(9r+c)*8] of `wr_data`, is array row 4j+r, column 4i+c when c < Sx and r < Sy, and 0 otherwise. Sx is 9 on a fractional x axis and 4 on an integer one. Sy follows the same rule for y.
- R8: The window for sub-block row j is written once 4j+Sy rows have arrived. On a 16-tall partition with fractional y, writes therefore begin before the last of its 21 rows is sent.
- R9: `busy` rises the cycle after an accepted `start` and falls in the cycle of the last window write. The following partition then reuses the array.
- R10: Size selector codes 0, 1 and 2 on `part_w_sel` and `part_h_sel` select 4, 8 and 16 pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a partition (accepted only when not busy) |
| part_w_sel | input | 2 | Partition width code (0:4, 1:8, 2:16) |
| part_h_sel | input | 2 | Partition height code (0:4, 1:8, 2:16) |
| sub_x | input | 2 | Partition's first 4x4 column within the macroblock |
| sub_y | input | 2 | Partition's first 4x4 row within the macroblock |
| pos_x | input | 12 | Partition top-left x in the frame, pixels |
| pos_y | input | 12 | Partition top-left y in the frame, pixels |
| mv_x | input | 12 | Signed quarter-pel horizontal motion vector |
| mv_y | input | 12 | Signed quarter-pel vertical motion vector |
| busy | output | 1 | Partition in progress |
| req_valid | output | 1 | One-cycle request strobe |
| req_x | output | 14 | Signed request origin x |
| req_y | output | 14 | Signed request origin y |
| req_w | output | 5 | Request width in pixels |
| req_h | output | 5 | Request height in rows |
| row_valid | input | 1 | Returned row beat valid |
| row_data | input | 168 | Returned row, 21 pixels |
| wr_en | output | 1 | Buffer write strobe |
| wr_idx | output | 4 | Buffer entry (macroblock 4x4 index) |
| wr_data | output | 648 | 9x9 window, row-major |

## Verification
The bench sweeps every width and height code against all four combinations of integer and fractional vector components. It uses negative vectors so that a truncating instead of flooring division shifts the origin by one pixel, and a missing two-pixel pull-back on a fractional axis shows up in the same way. A design that sized both axes as fractional would put filled pixels where integer-axis windows must hold zero. Nonzero sub-block offsets expose a wrong entry index or a column-major write order. A restart pulsed mid-partition would show up as a second request or as corrupted windows. A collector that waited for the full window before writing fails the check that writes have begun before the final row of a 21-row fetch.

// File: rtl/rfc_pkg.sv
`timescale 1ns/1ps
package rfc_pkg;
    localparam int SUB      = 4;
    localparam int SUB_SH   = $clog2(SUB);
    localparam int EXT      = 5;
    localparam int MAX_PART = 16;
    localparam int ARR_DIM  = MAX_PART + EXT;
    localparam int WIN      = SUB + EXT;
    localparam int MB_SUBS  = MAX_PART / SUB;
    localparam int DIM_W    = $clog2(ARR_DIM + 1);
    localparam int SUBIDX_W = $clog2(MB_SUBS);
    localparam int BLKCNT_W = $clog2(MB_SUBS + 1);
    localparam int ENTRY_W  = 2 * SUBIDX_W;

    typedef struct packed {
        logic [BLKCNT_W-1:0] nblk_w;
        logic [BLKCNT_W-1:0] nblk_h;
        logic [SUBIDX_W-1:0] sub_x;
        logic [SUBIDX_W-1:0] sub_y;
        logic                frac_x;
        logic                frac_y;
    } part_cfg_t;

    function automatic logic [DIM_W-1:0] side_pixels(input logic [1:0] sel);
        case (sel)
            2'd0:    return DIM_W'(SUB);
            2'd1:    return DIM_W'(2 * SUB);
            default: return DIM_W'(MAX_PART);
        endcase
    endfunction

    function automatic logic [BLKCNT_W-1:0] side_blocks(input logic [1:0] sel);
        case (sel)
            2'd0:    return BLKCNT_W'(1);
            2'd1:    return BLKCNT_W'(2);
            default: return BLKCNT_W'(MB_SUBS);
        endcase
    endfunction

    function automatic logic [DIM_W-1:0] fetch_extent(input logic [DIM_W-1:0] side,
                                                      input logic frac);
        return frac ? side + DIM_W'(EXT) : side;
    endfunction

    function automatic logic [DIM_W-1:0] tap_span(input logic frac);
        return frac ? DIM_W'(WIN) : DIM_W'(SUB);
    endfunction
endpackage

// File: rtl/rfc_request.sv
`timescale 1ns/1ps
module rfc_request
    import rfc_pkg::*;
#(
    parameter int POS_W     = 12,
    parameter int MV_W      = 12,
    parameter int FRAC_BITS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    busy,
    input  logic [1:0]              part_w_sel,
    input  logic [1:0]              part_h_sel,
    input  logic [SUBIDX_W-1:0]     sub_x,
    input  logic [SUBIDX_W-1:0]     sub_y,
    input  logic [POS_W-1:0]        pos_x,
    input  logic [POS_W-1:0]        pos_y,
    input  logic signed [MV_W-1:0]  mv_x,
    input  logic signed [MV_W-1:0]  mv_y,
    output logic                    accept,
    output part_cfg_t               cfg,
    output logic                    req_valid,
    output logic signed [POS_W+1:0] req_x,
    output logic signed [POS_W+1:0] req_y,
    output logic [DIM_W-1:0]        req_w,
    output logic [DIM_W-1:0]        req_h
);
    localparam int ORG_W = POS_W + 2;

    logic fx, fy;
    logic signed [ORG_W-1:0] org_x_c, org_y_c;

    assign fx     = |mv_x[FRAC_BITS-1:0];
    assign fy     = |mv_y[FRAC_BITS-1:0];
    assign accept = start && !busy;

    // integer-pel target, pulled back by two on fractional axes for filter context
    always_comb begin
        org_x_c = $signed({2'b00, pos_x}) + ORG_W'(mv_x >>> FRAC_BITS)
                  - (fx ? ORG_W'(2) : ORG_W'(0));
        org_y_c = $signed({2'b00, pos_y}) + ORG_W'(mv_y >>> FRAC_BITS)
                  - (fy ? ORG_W'(2) : ORG_W'(0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_x     <= '0;
            req_y     <= '0;
            req_w     <= '0;
            req_h     <= '0;
            cfg       <= '0;
        end else begin
            req_valid <= accept;
            if (accept) begin
                req_x      <= org_x_c;
                req_y      <= org_y_c;
                req_w      <= fetch_extent(side_pixels(part_w_sel), fx);
                req_h      <= fetch_extent(side_pixels(part_h_sel), fy);
                cfg.nblk_w <= side_blocks(part_w_sel);
                cfg.nblk_h <= side_blocks(part_h_sel);
                cfg.sub_x  <= sub_x;
                cfg.sub_y  <= sub_y;
                cfg.frac_x <= fx;
                cfg.frac_y <= fy;
            end
        end
    end

    // R2: the request strobe lasts a single cycle
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R2: only the six legal extents ever appear on a request
    p_req_size_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_w == 5'd4 || req_w == 5'd8 || req_w == 5'd16 ||
                        req_w == 5'd9 || req_w == 5'd13 || req_w == 5'd21) &&
                       (req_h == 5'd4 || req_h == 5'd8 || req_h == 5'd16 ||
                        req_h == 5'd9 || req_h == 5'd13 || req_h == 5'd21)));

    // R4: a start during a busy partition yields no request
    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> !req_valid);
endmodule

// File: rtl/rfc_row_store.sv
`timescale 1ns/1ps
module rfc_row_store
    import rfc_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         busy,
    input  logic                         row_valid,
    input  logic [DIM_W-1:0]             rows_wanted,
    input  logic [ARR_DIM*PIX_W-1:0]     row_data,
    output logic [DIM_W-1:0]             row_cnt,
    output logic [ARR_DIM-1:0][ARR_DIM-1:0][PIX_W-1:0] pix
);
    logic take;

    assign take = row_valid && busy && (row_cnt < rows_wanted);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_cnt <= '0;
        end else if (clear) begin
            row_cnt <= '0;
        end else if (take) begin
            row_cnt <= row_cnt + DIM_W'(1);
        end
    end

    // pixel storage carries no reset; rows are always written before being read
    always_ff @(posedge clk) begin
        if (take) begin
            pix[row_cnt] <= row_data;
        end
    end

    // R5: never more rows than the request asked for
    p_rows_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        row_cnt <= rows_wanted);
endmodule

// File: rtl/rfc_emitter.sv
`timescale 1ns/1ps
module rfc_emitter
    import rfc_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         accept,
    input  part_cfg_t                    cfg,
    input  logic [DIM_W-1:0]             row_cnt,
    input  logic [ARR_DIM-1:0][ARR_DIM-1:0][PIX_W-1:0] pix,
    output logic                         busy,
    output logic                         wr_en,
    output logic [ENTRY_W-1:0]           wr_idx,
    output logic [WIN*WIN*PIX_W-1:0]     wr_data
);
    logic [SUBIDX_W-1:0] cur_i, cur_j;
    logic [DIM_W-1:0]    base_r, base_c, span_x, span_y, need_rows;
    logic                ready, last_i, last_j;
    logic [WIN*WIN-1:0][PIX_W-1:0] win;

    assign base_r    = DIM_W'(cur_j) << SUB_SH;
    assign base_c    = DIM_W'(cur_i) << SUB_SH;
    assign span_x    = tap_span(cfg.frac_x);
    assign span_y    = tap_span(cfg.frac_y);
    assign need_rows = base_r + span_y;
    assign ready     = busy && (row_cnt >= need_rows);
    assign last_i    = (BLKCNT_W'(cur_i) == cfg.nblk_w - BLKCNT_W'(1));
    assign last_j    = (BLKCNT_W'(cur_j) == cfg.nblk_h - BLKCNT_W'(1));

    // one tap per window position; taps outside the fetched span read as zero
    for (genvar gr = 0; gr < WIN; gr++) begin : g_row
        for (genvar gc = 0; gc < WIN; gc++) begin : g_col
            logic [DIM_W-1:0] rr, cc;
            assign rr = base_r + DIM_W'(gr);
            assign cc = base_c + DIM_W'(gc);
            assign win[gr*WIN+gc] = (DIM_W'(gc) < span_x && DIM_W'(gr) < span_y)
                                    ? pix[rr][cc] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            cur_i   <= '0;
            cur_j   <= '0;
        end else begin
            wr_en <= ready;
            if (accept) begin
                busy  <= 1'b1;
                cur_i <= '0;
                cur_j <= '0;
            end else if (ready) begin
                wr_data <= win;
                wr_idx  <= {cfg.sub_y + cur_j, cfg.sub_x + cur_i};
                if (last_i) begin
                    cur_i <= '0;
                    if (last_j) begin
                        busy <= 1'b0;
                    end else begin
                        cur_j <= cur_j + SUBIDX_W'(1);
                    end
                end else begin
                    cur_i <= cur_i + SUBIDX_W'(1);
                end
            end
        end
    end

    // R9: writes only happen for a partition in progress
    p_wr_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(busy));

    // R9: busy ends together with the final window write
    p_busy_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> wr_en);

    // R6: consecutive writes within a partition never repeat an entry
    p_entry_moves_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && $past(busy, 2)) |-> (wr_idx != $past(wr_idx)));
endmodule

// File: rtl/ref_fetch_collector.sv
`timescale 1ns/1ps
module ref_fetch_collector
    import rfc_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int POS_W     = 12,
    parameter int MV_W      = 12,
    parameter int FRAC_BITS = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [1:0]                part_w_sel,
    input  logic [1:0]                part_h_sel,
    input  logic [SUBIDX_W-1:0]       sub_x,
    input  logic [SUBIDX_W-1:0]       sub_y,
    input  logic [POS_W-1:0]          pos_x,
    input  logic [POS_W-1:0]          pos_y,
    input  logic signed [MV_W-1:0]    mv_x,
    input  logic signed [MV_W-1:0]    mv_y,
    output logic                      busy,
    output logic                      req_valid,
    output logic signed [POS_W+1:0]   req_x,
    output logic signed [POS_W+1:0]   req_y,
    output logic [DIM_W-1:0]          req_w,
    output logic [DIM_W-1:0]          req_h,
    input  logic                      row_valid,
    input  logic [ARR_DIM*PIX_W-1:0]  row_data,
    output logic                      wr_en,
    output logic [ENTRY_W-1:0]        wr_idx,
    output logic [WIN*WIN*PIX_W-1:0]  wr_data
);
    logic             accept;
    part_cfg_t        cfg;
    logic [DIM_W-1:0] row_cnt;
    logic [ARR_DIM-1:0][ARR_DIM-1:0][PIX_W-1:0] pix;

    rfc_request #(.POS_W(POS_W), .MV_W(MV_W), .FRAC_BITS(FRAC_BITS)) u_req (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .part_w_sel(part_w_sel), .part_h_sel(part_h_sel),
        .sub_x(sub_x), .sub_y(sub_y), .pos_x(pos_x), .pos_y(pos_y),
        .mv_x(mv_x), .mv_y(mv_y), .accept(accept), .cfg(cfg),
        .req_valid(req_valid), .req_x(req_x), .req_y(req_y),
        .req_w(req_w), .req_h(req_h)
    );

    rfc_row_store #(.PIX_W(PIX_W)) u_rows (
        .clk(clk), .rst(rst), .clear(accept), .busy(busy),
        .row_valid(row_valid), .rows_wanted(req_h), .row_data(row_data),
        .row_cnt(row_cnt), .pix(pix)
    );

    rfc_emitter #(.PIX_W(PIX_W)) u_emit (
        .clk(clk), .rst(rst), .accept(accept), .cfg(cfg),
        .row_cnt(row_cnt), .pix(pix), .busy(busy),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );
endmodule

// File: tb/sim_ref_fetch_collector.sv
`timescale 1ns/1ps
module sim_ref_fetch_collector;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   part_w_sel = '0, part_h_sel = '0, sub_x = '0, sub_y = '0;
    logic [11:0]  pos_x = '0, pos_y = '0;
    logic signed [11:0] mv_x = '0, mv_y = '0;
    logic         busy, req_valid, wr_en, row_valid = 1'b0;
    logic signed [13:0] req_x, req_y;
    logic [4:0]   req_w, req_h;
    logic [167:0] row_data = '0;
    logic [3:0]   wr_idx;
    logic [647:0] wr_data;

    int checks = 0, errors = 0;
    int nw = 0, nreq = 0;
    logic [3:0]   got_idx [0:63];
    logic [647:0] got_dat [0:63];
    int rq_x, rq_y, rq_w, rq_h;

    always #5 clk = ~clk;

    ref_fetch_collector u0 (
        .clk(clk), .rst(rst), .start(start), .part_w_sel(part_w_sel),
        .part_h_sel(part_h_sel), .sub_x(sub_x), .sub_y(sub_y),
        .pos_x(pos_x), .pos_y(pos_y), .mv_x(mv_x), .mv_y(mv_y),
        .busy(busy), .req_valid(req_valid), .req_x(req_x), .req_y(req_y),
        .req_w(req_w), .req_h(req_h), .row_valid(row_valid),
        .row_data(row_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (wr_en && nw < 64) begin
            got_idx[nw] = wr_idx;
            got_dat[nw] = wr_data;
            nw = nw + 1;
        end
        if (req_valid) begin
            nreq = nreq + 1;
            rq_x = int'(req_x);
            rq_y = int'(req_y);
            rq_w = int'(req_w);
            rq_h = int'(req_h);
        end
    end

    function automatic logic [7:0] pixv(int s, int r, int c);
        return 8'((r * 29 + c * 7 + s * 13 + 5));
    endfunction

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic run_part(input int s, input int ws, input int hs, input bit fx,
                            input bit fy, input int sx, input int sy, input int px,
                            input int py, input int mvx, input int mvy, input bit poke);
        int m = 4 << ws, n = 4 << hs;
        int ew = m + (fx ? 5 : 0), eh = n + (fy ? 5 : 0);
        int ex = px + (mvx >>> 2) - (fx ? 2 : 0);
        int ey = py + (mvy >>> 2) - (fy ? 2 : 0);
        int spx = fx ? 9 : 4, spy = fy ? 9 : 4;
        int before_last = 0, t = 0, k = 0;
        logic [647:0] ev;
        @(negedge clk); #1;
        nw = 0; nreq = 0;
        part_w_sel = 2'(ws); part_h_sel = 2'(hs);
        sub_x = 2'(sx); sub_y = 2'(sy);
        pos_x = 12'(px); pos_y = 12'(py);
        mv_x = 12'(mvx); mv_y = 12'(mvy);
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        if (poke) begin
            // R4: restart attempt with different geometry while busy
            part_w_sel = 2'(2 - ws); part_h_sel = 2'(2 - hs);
            pos_x = 12'(px + 40); mv_x = 12'(mvx + 5); mv_y = 12'(mvy + 6);
            start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
        end
        for (k = 0; k < eh; k++) begin
            if (k == eh - 1) before_last = nw;
            for (int c = 0; c < 21; c++)
                row_data[c*8 +: 8] = (c < ew) ? pixv(s, k, c) : 8'hEE;
            row_valid = 1'b1;
            @(negedge clk); #1;
        end
        row_valid = 1'b0;
        while (busy && t < 200) begin
            @(negedge clk);
            t++;
        end
        #1;
        chk(!busy, $sformatf("R9 part %0d busy act %0d exp 0", s, busy));
        chk(nreq == 1, $sformatf("R2 R4 part %0d request count act %0d exp 1", s, nreq));
        chk(rq_w == ew && rq_h == eh,
            $sformatf("R2 R10 part %0d size act %0dx%0d exp %0dx%0d", s, rq_w, rq_h, ew, eh));
        chk(rq_x == ex && rq_y == ey,
            $sformatf("R3 part %0d origin act (%0d,%0d) exp (%0d,%0d)", s, rq_x, rq_y, ex, ey));
        chk(nw == (m / 4) * (n / 4),
            $sformatf("R6 part %0d write count act %0d exp %0d", s, nw, (m / 4) * (n / 4)));
        if (fy && hs == 2)
            chk(before_last > 0,
                $sformatf("R8 part %0d writes before final row act %0d exp >0", s, before_last));
        for (int j = 0; j < n / 4; j++) begin
            for (int i = 0; i < m / 4; i++) begin
                int e = j * (m / 4) + i;
                int eidx = (sy + j) * 4 + sx + i;
                for (int r = 0; r < 9; r++)
                    for (int c = 0; c < 9; c++)
                        ev[(r*9+c)*8 +: 8] = (c < spx && r < spy)
                                             ? pixv(s, 4 * j + r, 4 * i + c) : 8'h00;
                if (e < nw) begin
                    chk(int'(got_idx[e]) == eidx,
                        $sformatf("R6 part %0d write %0d idx act %0d exp %0d",
                                  s, e, got_idx[e], eidx));
                    if (got_dat[e] !== ev) begin
                        int fr = 0, fc = 0;
                        for (int q = 80; q >= 0; q--)
                            if (got_dat[e][q*8 +: 8] !== ev[q*8 +: 8]) begin
                                fr = q / 9; fc = q % 9;
                            end
                        chk(1'b0, $sformatf("R7 R5 part %0d write %0d pixel(%0d,%0d) act %0d exp %0d",
                            s, e, fr, fc, got_dat[e][(fr*9+fc)*8 +: 8], ev[(fr*9+fc)*8 +: 8]));
                    end else begin
                        chk(1'b1, "R7");
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog busy act %0d exp 0", busy);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s = 0;
        @(negedge clk);
        chk(!busy && !req_valid && !wr_en,
            $sformatf("R1 in reset act %0d%0d%0d exp 000", busy, req_valid, wr_en));
        @(negedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !req_valid && !wr_en,
            $sformatf("R1 after reset act %0d%0d%0d exp 000", busy, req_valid, wr_en));
        for (int ws = 0; ws < 3; ws++)
            for (int hs = 0; hs < 3; hs++)
                for (int fc = 0; fc < 4; fc++) begin
                    bit fx = fc[0], fy = fc[1];
                    int nbw = 1 << ws, nbh = 1 << hs;
                    int sx = (ws + hs + fc) % (5 - nbw);
                    int sy = (ws + 2 * hs + fc) % (5 - nbh);
                    int kx = ws * 5 - hs * 3 - 2 + fc;
                    int ky = hs * 4 - ws * 2 - 3;
                    int mvx = 4 * kx + (fx ? 1 + s % 3 : 0);
                    int mvy = 4 * ky + (fy ? 3 - s % 3 : 0);
                    run_part(s, ws, hs, fx, fy, sx, sy, 100 + s * 37, 60 + s * 11,
                             mvx, mvy, s == 7 || s == 30);
                    s++;
                end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule